// File: doc/BRIEF.md
# Ripple arithmetic slice

An eight-bit arithmetic slice built as a chain of identical bit cells. Each cell forms a propagate term and a generate term from its own pair of operand bits. The propagate term decides whether the cell passes its incoming carry upward or replaces it with the generate term. The carry leaving the top cell is a port, so slices can be stacked into wider datapaths.

A one-bit submode select picks between two uses of the chain.

- **Arithmetic submode:** the two operand buses are added, or the second is subtracted from the first.
- **Counter submode:** the slice's own result register is fed back as the first operand and stepped up or down by one.

A single control line carries both meanings: add/subtract in the arithmetic submode, up/down in the counter submode. The result is available combinationally and also captured in a register on every rising clock edge. That register can be preset from a parallel data bus.

Top module: `ripple_slice`

## Requirements
- R1: With `sub_mode`=0 and `dir_ctl`=1, `{carry_out,f_comb}` equals `a_bus + b_bus + carry_in` as a 9-bit sum.
- R2: With `sub_mode`=0 and `dir_ctl`=0, `{carry_out,f_comb}` equals `a_bus + ~b_bus + carry_in`. With `carry_in`=1 this is `a_bus - b_bus` modulo 256, and `carry_out`=1 exactly when `a_bus >= b_bus`.
- R3: The carry ripples through all eight cells. For example, `a_bus`=FF, `b_bus`=00, addition and `carry_in`=1 give `f_comb`=00 and `carry_out`=1.
- R4: With `sub_mode`=1 and `dir_ctl`=1, `{carry_out,f_comb}` equals `q_reg + 1 + carry_in`.
- R5: With `sub_mode`=1 and `dir_ctl`=0, `{carry_out,f_comb}` equals `q_reg + FF + carry_in`. With `carry_in`=0 this is `q_reg - 1`.
- R6: The counter wraps modulo 256 in both directions. Counting up from FF gives 00 with `carry_out`=1. Counting down from 00 gives FF with `carry_out`=0.
- R7: On each rising edge with `rst`=0 and `load_en`=0, `q_reg` takes the value `f_comb` had before the edge, in either submode.
- R8: On a rising edge with `rst`=0 and `load_en`=1, `q_reg` takes `load_data`. This holds in the counter submode too, so loading overrides the count step.
- R9: On a rising edge with `rst`=1, `q_reg` becomes 00, even when `load_en`=1 in the same cycle.
- R10: In the counter submode, `a_bus` and `b_bus` have no effect on `f_comb` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a_bus | input | 8 | First operand (arithmetic submode) |
| b_bus | input | 8 | Second operand (arithmetic submode) |
| carry_in | input | 1 | Carry into bit 0 |
| dir_ctl | input | 1 | 1 = add / count up; 0 = subtract / count down |
| sub_mode | input | 1 | 0 = arithmetic, 1 = counter |
| load_en | input | 1 | Parallel preset strobe |
| load_data | input | 8 | Preset value for the register |
| f_comb | output | 8 | Combinational result |
| q_reg | output | 8 | Registered result / present count |
| carry_out | output | 1 | Carry out of bit 7 |

## Verification
The functions that collide are the load strobe and the count step. In the counter submode, a cycle with `load_en` high also presents a valid incremented or decremented value on `f_comb`. The bench raises the strobe while counting is selected and requires `q_reg` to show `load_data` rather than the stepped value. It then raises reset together with the load and requires zero. The arithmetic and counter results themselves are swept over every operand, control and carry combination and compared against plain integer sums.

// File: rtl/rslice_pkg.sv
package rslice_pkg;

    localparam int SLICE_W = 8;

    typedef enum logic {
        SM_ARITH = 1'b0,
        SM_COUNT = 1'b1
    } submode_e;

endpackage

// File: rtl/rslice_bit.sv
module rslice_bit (
    input  logic x_i,
    input  logic y_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    logic prop;
    logic gen;

    always_comb begin
        prop   = x_i ^ y_i;
        gen    = x_i & y_i;
        cout_o = prop ? cin_i : gen;
        sum_o  = prop ^ cin_i;
    end
endmodule

// File: rtl/rslice_opsel.sv
module rslice_opsel
    import rslice_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  submode_e           mode_i,
    input  logic               ctl_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [WIDTH-1:0]   cnt_i,
    output logic [WIDTH-1:0]   x_o,
    output logic [WIDTH-1:0]   y_o
);
    localparam logic [WIDTH-1:0] STEP_UP   = WIDTH'(1);
    localparam logic [WIDTH-1:0] STEP_DOWN = {WIDTH{1'b1}};

    always_comb begin
        unique case (mode_i)
            SM_ARITH: begin
                x_o = a_i;
                y_o = ctl_i ? b_i : ~b_i;
            end
            SM_COUNT: begin
                x_o = cnt_i;
                y_o = ctl_i ? STEP_UP : STEP_DOWN;
            end
            default: begin
                x_o = a_i;
                y_o = b_i;
            end
        endcase
    end
endmodule

// File: rtl/rslice_store.sv
module rslice_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic [WIDTH-1:0] next_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (load_i)
            q_o <= load_val_i;
        else
            q_o <= next_i;
    end
endmodule

// File: rtl/ripple_slice.sv
module ripple_slice
    import rslice_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_bus,
    input  logic [WIDTH-1:0] b_bus,
    input  logic             carry_in,
    input  logic             dir_ctl,
    input  logic             sub_mode,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] f_comb,
    output logic [WIDTH-1:0] q_reg,
    output logic             carry_out
);
    submode_e         mode;
    logic [WIDTH-1:0] x_op;
    logic [WIDTH-1:0] y_op;
    logic [WIDTH:0]   chain;

    assign mode     = submode_e'(sub_mode);
    assign chain[0] = carry_in;

    rslice_opsel #(.WIDTH(WIDTH)) u_opsel (
        .mode_i (mode),
        .ctl_i  (dir_ctl),
        .a_i    (a_bus),
        .b_i    (b_bus),
        .cnt_i  (q_reg),
        .x_o    (x_op),
        .y_o    (y_op)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        rslice_bit u_bit (
            .x_i    (x_op[i]),
            .y_i    (y_op[i]),
            .cin_i  (chain[i]),
            .sum_o  (f_comb[i]),
            .cout_o (chain[i+1])
        );
    end

    assign carry_out = chain[WIDTH];

    rslice_store #(.WIDTH(WIDTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_en),
        .load_val_i (load_data),
        .next_i     (f_comb),
        .q_o        (q_reg)
    );
endmodule

// File: rtl/rslice_chk.sv
module rslice_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_bus,
    input logic [WIDTH-1:0] b_bus,
    input logic             carry_in,
    input logic             dir_ctl,
    input logic             sub_mode,
    input logic             load_en,
    input logic [WIDTH-1:0] load_data,
    input logic [WIDTH-1:0] f_comb,
    input logic [WIDTH-1:0] q_reg,
    input logic             carry_out
);
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (!sub_mode && dir_ctl) |-> {carry_out, f_comb} ==
            ({1'b0, a_bus} + {1'b0, b_bus} + (WIDTH+1)'(carry_in))); // R1

    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
        (!sub_mode && !dir_ctl) |-> {carry_out, f_comb} ==
            ({1'b0, a_bus} + {1'b0, ~b_bus} + (WIDTH+1)'(carry_in))); // R2

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
        (sub_mode && dir_ctl) |-> {carry_out, f_comb} ==
            ({1'b0, q_reg} + (WIDTH+1)'(1) + (WIDTH+1)'(carry_in))); // R4

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (sub_mode && !dir_ctl) |-> {carry_out, f_comb} ==
            ({1'b0, q_reg} + {1'b0, {WIDTH{1'b1}}} + (WIDTH+1)'(carry_in))); // R5

    AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> q_reg == $past(f_comb)); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> q_reg == $past(load_data)); // R8
endmodule

bind ripple_slice rslice_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_bus     (a_bus),
    .b_bus     (b_bus),
    .carry_in  (carry_in),
    .dir_ctl   (dir_ctl),
    .sub_mode  (sub_mode),
    .load_en   (load_en),
    .load_data (load_data),
    .f_comb    (f_comb),
    .q_reg     (q_reg),
    .carry_out (carry_out)
);

// File: tb/sim_ripple_slice.sv
module sim_ripple_slice;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a_bus, b_bus, load_data;
    logic       carry_in, dir_ctl, sub_mode, load_en;
    logic [7:0] f_comb, q_reg;
    logic       carry_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ripple_slice u0 (
        .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus),
        .carry_in(carry_in), .dir_ctl(dir_ctl), .sub_mode(sub_mode),
        .load_en(load_en), .load_data(load_data),
        .f_comb(f_comb), .q_reg(q_reg), .carry_out(carry_out)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; a_bus = '0; b_bus = '0; load_data = 8'hAA;
        carry_in = 1'b0; dir_ctl = 1'b1; sub_mode = 1'b0; load_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 reset clears, beats load", {1'b0, q_reg}, 9'h000);

        // R1 R2 R3: exhaustive arithmetic sweep, register parked on load
        @(negedge clk);
        rst = 1'b0; load_en = 1'b1; load_data = 8'h5A; sub_mode = 1'b0;
        for (int c = 0; c < 2; c++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < 256; a++)
                    for (int b = 0; b < 256; b++) begin
                        int e;
                        dir_ctl = c[0]; carry_in = ci[0];
                        a_bus = a[7:0]; b_bus = b[7:0];
                        e = a + (c == 1 ? b : 255 - b) + ci;
                        #1;
                        chk(c == 1 ? "R1 add" : "R2 sub", {carry_out, f_comb}, 9'(e));
                    end

        @(negedge clk);
        dir_ctl = 1'b1; carry_in = 1'b1; a_bus = 8'hFF; b_bus = 8'h00;
        #1 chk("R3 full ripple", {carry_out, f_comb}, 9'h100);
        dir_ctl = 1'b0; a_bus = 8'h10; b_bus = 8'h20;
        #1 chk("R2 borrow", {carry_out, f_comb}, 9'h0F0);

        // R7 arithmetic result registered
        @(negedge clk);
        load_en = 1'b0; dir_ctl = 1'b1; carry_in = 1'b1; a_bus = 8'h37; b_bus = 8'h21;
        @(negedge clk);
        chk("R7 arith registered", {1'b0, q_reg}, 9'h059);

        // R4 R5 R10: counter sweep over every present count
        sub_mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            load_en = 1'b1; load_data = v[7:0];
            @(negedge clk);
            chk("R8 load", {1'b0, q_reg}, {1'b0, v[7:0]});
            for (int c = 0; c < 2; c++)
                for (int ci = 0; ci < 2; ci++) begin
                    int e;
                    dir_ctl = c[0]; carry_in = ci[0];
                    a_bus = 8'(v * 7); b_bus = 8'(v ^ 8'h3C);
                    e = v + (c == 1 ? 1 : 255) + ci;
                    #1;
                    chk(c == 1 ? "R4 count up" : "R5 count down", {carry_out, f_comb}, 9'(e));
                end
            @(negedge clk);
            load_en = 1'b0; dir_ctl = v[0]; carry_in = v[1];
            @(negedge clk);
            chk("R7 count registered", {1'b0, q_reg},
                {1'b0, 8'(v + (v[0] ? 1 : 255) + int'(v[1]))});
        end

        // R10: operand buses ignored in counter submode
        load_en = 1'b1; load_data = 8'h40; dir_ctl = 1'b1; carry_in = 1'b0;
        @(negedge clk);
        load_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            a_bus = 8'(k * 85); b_bus = 8'(255 - k * 60);
            #1 chk("R10 buses ignored", {carry_out, f_comb}, 9'h041);
        end

        // R6 wrap up from FE
        @(negedge clk);
        load_data = 8'hFE;
        @(negedge clk);
        load_en = 1'b0;
        #1 chk("R6 up pre-wrap", {carry_out, f_comb}, 9'h0FF);
        @(negedge clk);
        #1 chk("R6 up wrap carry", {carry_out, f_comb}, 9'h100);
        @(negedge clk);
        chk("R6 up wrapped", {1'b0, q_reg}, 9'h000);

        // R6 wrap down from 00
        dir_ctl = 1'b0;
        #1 chk("R6 down wrap carry", {carry_out, f_comb}, 9'h0FF);
        @(negedge clk);
        chk("R6 down wrapped", {1'b0, q_reg}, 9'h0FF);

        // R8 load beats count step in the same cycle
        load_en = 1'b1; load_data = 8'h13; dir_ctl = 1'b1;
        @(negedge clk);
        chk("R8 load beats count", {1'b0, q_reg}, 9'h013);

        // R9 reset beats load in the same cycle
        rst = 1'b1; load_data = 8'h77;
        @(negedge clk);
        chk("R9 reset beats load", {1'b0, q_reg}, 9'h000);
        rst = 1'b0; load_en = 1'b0;
        @(negedge clk);
        chk("R4 count after reset", {1'b0, q_reg}, 9'h001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule